// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames on a single transmit line. Bytes enter through a valid/ready port into a small FIFO. A control state machine takes them out one at a time and sends each as a frame: a low start bit, then the data bits least significant first, an optional parity bit, and a stop period at the high level. All bit timing is counted in pulses of a baud tick input that runs at sixteen times the bit rate.

A 32-bit configuration word is written through a plain write strobe and sets the frame format. It selects a character length of five to eight bits and whether parity is used, with even or odd sense. The stop period can be one, one and a half or two bits long. The word can also invert the output line, make each new frame wait for a clear-to-send input (whose sensed level can be flipped), and send all-zero characters whenever the FIFO runs dry. Writing a one to the clear bit of the word empties the FIFO.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, txdOut is 1, busy is 0 and inReady is 1. The configuration resets to 8 data bits, one stop bit, no parity, with every option off.
- R2: Each frame starts with one start bit at level 0 and sends its data bits least significant bit first. The stop period is at level 1. Start, data and parity bits each last 16 baud ticks.
- R3: Configuration bits [1:0] set the character length. Code 0 gives 5 data bits, 1 gives 6, 2 gives 7 and 3 gives 8. Only the low bits of the byte are sent.
- R4: When configuration bit 4 is 1, one parity bit follows the last data bit. When it is 0, no parity bit is sent.
- R5: Configuration bit 5 selects the parity sense. With 0 (even), the number of ones in the sent data bits plus the parity bit is even. With 1 (odd), that number is odd.
- R6: Configuration bits [3:2] set the stop period. Code 1 gives 16 ticks, 2 gives 24 ticks, 3 gives 32 ticks, and code 0 gives 16 ticks.
- R7: When configuration bit 6 is 1, txdOut is inverted at all times, including the idle level, which becomes 0.
- R8: When configuration bit 8 is 1, no new frame starts while the sensed clear-to-send is 0. The sensed level is ctsIn XOR configuration bit 7. A frame that has already started runs to its end.
- R9: When configuration bit 9 is 1 and the FIFO is empty, frames carrying an all-zero character are sent instead of idling. Flow control still applies to them.
- R10: A configuration write with bit 10 set empties the FIFO. Bytes that were queued are never sent.
- R11: The FIFO holds DEPTH (default 4) bytes. inReady is 0 while it is full. Bytes are sent in the order they were accepted.
- R12: busy is 1 from the clock that starts the start bit until the stop period ends. A frame therefore lasts exactly 16·(1 + data bits + parity bit) plus the stop ticks, in baud ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 32 | Configuration word |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| inValid | input | 1 | Byte offered to the FIFO |
| inData | input | 8 | Byte to queue |
| inReady | output | 1 | FIFO can accept a byte |
| ctsIn | input | 1 | Clear-to-send input |
| txdOut | output | 1 | Serial output line |
| busy | output | 1 | A frame is on the line |

## Verification
The assertions assume that the frame-format fields (character length, parity and stop length) are written only while busy is low. The data-bit index check and the frame-length arithmetic depend on those fields staying fixed for the whole frame. The bench keeps to this: it waits for the line to go idle before each format change. The only mid-frame write it makes clears the zero-fill bit and leaves the format fields unchanged. The assertions also take baudTick as a one-cycle pulse, and the bench drives it high on every other clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef struct packed {
    logic [1:0] charLen;
    logic [1:0] stopLen;
    logic       parityEn;
    logic       parityOdd;
    logic       txInvert;
    logic       ctsInvert;
    logic       flowEn;
    logic       nullSend;
  } txCfg_t;

  typedef enum logic [1:0] {
    LS_MARK,
    LS_START,
    LS_DATA,
    LS_PARITY
  } lineSel_t;

  typedef struct packed {
    logic     load;
    logic     useNull;
    logic     shift;
    lineSel_t lineSel;
  } txStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             pushValid,
  input  logic [WIDTH-1:0] pushData,
  output logic             pushReady,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CNTW-1:0]  count;
  logic             doPush, doPop;

  assign pushReady = (count != CNTW'(DEPTH));
  assign empty     = (count == '0);
  assign doPush    = pushValid && pushReady && !clear;
  assign doPop     = pop && !empty && !clear;
  assign headData  = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNTW'(DEPTH));

  // R10
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> empty);

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  txCfg_t    cfg,
  input  logic      baudTick,
  input  logic      fifoEmpty,
  input  logic      ctsIn,
  output txStrobe_t strobe,
  output logic      busy
);
  localparam int CW = $clog2(2 * OS);

  txState_t       state;
  logic [CW-1:0]  tickCnt;
  logic [2:0]     bitIdx;
  logic [3:0]     dataBits;
  logic [CW-1:0]  stopLast;
  logic           ctsOk, haveChar, bitEnd;

  assign ctsOk    = !cfg.flowEn || (ctsIn ^ cfg.ctsInvert);
  assign haveChar = !fifoEmpty || cfg.nullSend;
  assign dataBits = 4'd5 + {2'b00, cfg.charLen};
  assign bitEnd   = baudTick && (tickCnt == CW'(OS - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    case (cfg.stopLen)
      2'd2:    stopLast = CW'(OS + OS / 2 - 1);
      2'd3:    stopLast = CW'(2 * OS - 1);
      default: stopLast = CW'(OS - 1);
    endcase
  end

  always_comb begin
    strobe.load    = (state == ST_IDLE) && haveChar && ctsOk;
    strobe.useNull = fifoEmpty;
    strobe.shift   = (state == ST_DATA) && bitEnd;
    case (state)
      ST_START:  strobe.lineSel = LS_START;
      ST_DATA:   strobe.lineSel = LS_DATA;
      ST_PARITY: strobe.lineSel = LS_PARITY;
      default:   strobe.lineSel = LS_MARK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          bitIdx  <= '0;
          if (strobe.load) state <= ST_START;
        end
        ST_START: begin
          if (baudTick) tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
          if (bitEnd) state <= ST_DATA;
        end
        ST_DATA: begin
          if (baudTick) tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
          if (bitEnd) begin
            if ({1'b0, bitIdx} == dataBits - 4'd1)
              state <= cfg.parityEn ? ST_PARITY : ST_STOP;
            else
              bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_PARITY: begin
          if (baudTick) tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
          if (bitEnd) state <= ST_STOP;
        end
        ST_STOP: begin
          if (baudTick) begin
            if (tickCnt == stopLast) begin
              state   <= ST_IDLE;
              tickCnt <= '0;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  flow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cfg.flowEn && !(ctsIn ^ cfg.ctsInvert)) |=> (state == ST_IDLE));

  // R12
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && !baudTick) |=> (state == ST_STOP));

  // R3
  bit_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> ({1'b0, bitIdx} < dataBits));

endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  txCfg_t     cfg,
  input  txStrobe_t  strobe,
  input  logic [7:0] fifoData,
  output logic       txdOut
);
  logic [7:0] shiftReg;
  logic       parityBit;
  logic [7:0] charMask, nextChar;
  logic       lineRaw;

  assign charMask = 8'hFF >> (2'd3 - cfg.charLen);
  assign nextChar = (strobe.useNull ? 8'h00 : fifoData) & charMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else if (strobe.load) begin
      shiftReg  <= nextChar;
      parityBit <= (^nextChar) ^ cfg.parityOdd;
    end else if (strobe.shift) begin
      shiftReg  <= shiftReg >> 1;
    end
  end

  always_comb begin
    case (strobe.lineSel)
      LS_START:  lineRaw = 1'b0;
      LS_DATA:   lineRaw = shiftReg[0];
      LS_PARITY: lineRaw = parityBit;
      default:   lineRaw = 1'b1;
    endcase
  end

  assign txdOut = lineRaw ^ cfg.txInvert;

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !lineRaw);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int OS    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  input  logic        baudTick,
  input  logic        inValid,
  input  logic [7:0]  inData,
  output logic        inReady,
  input  logic        ctsIn,
  output logic        txdOut,
  output logic        busy
);
  txCfg_t     cfg;
  txStrobe_t  strobe;
  logic       fifoEmpty, fifoClear;
  logic [7:0] headData;

  assign fifoClear = cfgWrEn && cfgWrData[10];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg         <= '0;
      cfg.charLen <= 2'd3;
      cfg.stopLen <= 2'd1;
    end else if (cfgWrEn) begin
      cfg.charLen   <= cfgWrData[1:0];
      cfg.stopLen   <= cfgWrData[3:2];
      cfg.parityEn  <= cfgWrData[4];
      cfg.parityOdd <= cfgWrData[5];
      cfg.txInvert  <= cfgWrData[6];
      cfg.ctsInvert <= cfgWrData[7];
      cfg.flowEn    <= cfgWrData[8];
      cfg.nullSend  <= cfgWrData[9];
    end
  end

  uart_tx_fifo #(.DEPTH(DEPTH), .WIDTH(8)) fifo (
    .clk(clk), .rstN(rstN), .clear(fifoClear),
    .pushValid(inValid), .pushData(inData), .pushReady(inReady),
    .pop(strobe.load && !strobe.useNull), .headData(headData), .empty(fifoEmpty)
  );

  uart_tx_ctrl #(.OS(OS)) ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .baudTick(baudTick),
    .fifoEmpty(fifoEmpty), .ctsIn(ctsIn), .strobe(strobe), .busy(busy)
  );

  uart_tx_dp dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe),
    .fifoData(headData), .txdOut(txdOut)
  );

endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        baudTick = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inReady;
  logic        ctsIn = 1'b1;
  logic        txdOut;
  logic        busy;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  uart_frame_tx dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .baudTick(baudTick), .inValid(inValid), .inData(inData), .inReady(inReady),
    .ctsIn(ctsIn), .txdOut(txdOut), .busy(busy)
  );

  always #4 clk = ~clk;

  // Monitor: decode frames at mid-bit; count ticks applied while busy.
  logic [11:0] frBits [32];
  int          frTicks [32];
  int          frCount = 0;
  logic [11:0] curBits = '1;
  int          tickIdx = 0;
  bit          prevBusy = 0;
  bit          benchInv = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevBusy = 0;
      tickIdx  = 0;
      baudTick = 1'b0;
    end else begin
      if (prevBusy && baudTick) begin
        tickIdx++;
        if (tickIdx % 16 == 8 && tickIdx / 16 < 12)
          curBits[tickIdx / 16] = txdOut ^ benchInv;
      end
      if (busy && !prevBusy) begin
        tickIdx = 0;
        curBits = '1;
      end
      if (!busy && prevBusy && frCount < 32) begin
        frBits[frCount]  = curBits;
        frTicks[frCount] = tickIdx;
        frCount++;
      end
      prevBusy = busy;
      baudTick = ~baudTick;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] w);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = w;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    inData = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitFrames(input int target);
    int n = 0;
    while (frCount < target && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(frCount >= target, "R12 frame completion", frCount, target);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic checkFrame(input int idx, input logic [7:0] expData, input int n,
                            input bit par, input bit odd, input int stopT, input string tag);
    logic [7:0] got = '0;
    logic [7:0] msk;
    msk = 8'hFF >> (8 - n);
    for (int i = 0; i < n; i++) got[i] = frBits[idx][1 + i];
    check(frBits[idx][0] == 1'b0, {tag, " start bit"}, frBits[idx][0], 0);
    check(got == (expData & msk), {tag, " data"}, got, expData & msk);
    if (par)
      check(frBits[idx][1 + n] == ((^(expData & msk)) ^ odd), {tag, " parity"},
            frBits[idx][1 + n], (^(expData & msk)) ^ odd);
    check(frBits[idx][1 + n + par] == 1'b1, {tag, " stop bit"}, frBits[idx][1 + n + par], 1);
    check(frTicks[idx] == 16 * (1 + n + par) + stopT, {tag, " R12 frame ticks"},
          frTicks[idx], 16 * (1 + n + par) + stopT);
  endtask

  task automatic sendAndCheck(input logic [31:0] w, input logic [7:0] d, input int n,
                              input bit par, input bit odd, input int stopT, input string tag);
    int base;
    writeCfg(w);
    base = frCount;
    pushByte(d);
    waitFrames(base + 1);
    checkFrame(base, d, n, par, odd, stopT, tag);
    waitIdle();
  endtask

  task automatic t_reset();
    check(txdOut == 1'b1, "R1 idle line", txdOut, 1);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(inReady == 1'b1, "R1 inReady", inReady, 1);
  endtask

  task automatic t_basic();
    int base = frCount;
    pushByte(8'hA5);
    waitFrames(base + 1);
    checkFrame(base, 8'hA5, 8, 0, 0, 16, "R1 R2 default 8N1");
    waitIdle();
  endtask

  task automatic t_charLen();
    for (int len = 0; len < 4; len++)
      sendAndCheck(32'(len) | 32'h4, 8'hD6, 5 + len, 0, 0, 16, "R3 char length");
  endtask

  task automatic t_parity();
    sendAndCheck(32'h14, 8'h13, 5, 1, 0, 16, "R4 R5 even parity");
    sendAndCheck(32'h3E, 8'h55, 7, 1, 1, 32, "R5 odd parity");
    sendAndCheck(32'h37, 8'h00, 8, 1, 1, 16, "R5 odd parity zero data");
    sendAndCheck(32'h07, 8'h81, 8, 0, 0, 16, "R4 parity off");
  endtask

  task automatic t_stop();
    sendAndCheck(32'h03, 8'h3C, 8, 0, 0, 16, "R6 stop code 0");
    sendAndCheck(32'h07, 8'h3C, 8, 0, 0, 16, "R6 stop code 1");
    sendAndCheck(32'h0B, 8'h3C, 8, 0, 0, 24, "R6 stop code 2");
    sendAndCheck(32'h0D, 8'h3C, 6, 0, 0, 32, "R6 stop code 3");
  endtask

  task automatic t_invert();
    writeCfg(32'h47);
    @(negedge clk);
    check(txdOut == 1'b0, "R7 inverted idle", txdOut, 0);
    benchInv = 1;
    sendAndCheck(32'h47, 8'h6A, 8, 0, 0, 16, "R7 inverted frame");
    benchInv = 0;
    writeCfg(32'h07);
    @(negedge clk);
    check(txdOut == 1'b1, "R7 restored idle", txdOut, 1);
  endtask

  task automatic t_flow();
    int base;
    ctsIn = 1'b0;
    writeCfg(32'h107);
    base = frCount;
    pushByte(8'h77);
    repeat (300) @(negedge clk);
    check(busy == 1'b0 && frCount == base, "R8 blocked by cts", frCount, base);
    ctsIn = 1'b1;
    waitFrames(base + 1);
    checkFrame(base, 8'h77, 8, 0, 0, 16, "R8 released");
    waitIdle();
    writeCfg(32'h187);
    base = frCount;
    pushByte(8'h11);
    repeat (300) @(negedge clk);
    check(busy == 1'b0 && frCount == base, "R8 inverted cts blocks", frCount, base);
    ctsIn = 1'b0;
    waitFrames(base + 1);
    checkFrame(base, 8'h11, 8, 0, 0, 16, "R8 inverted cts released");
    waitIdle();
    base = frCount;
    pushByte(8'h22);
    while (!busy) @(negedge clk);
    repeat (20) @(negedge clk);
    ctsIn = 1'b1;
    waitFrames(base + 1);
    checkFrame(base, 8'h22, 8, 0, 0, 16, "R8 frame completes after cts drop");
    waitIdle();
    ctsIn = 1'b1;
    writeCfg(32'h07);
  endtask

  task automatic t_fifo();
    int base;
    ctsIn = 1'b0;
    writeCfg(32'h107);
    for (int i = 1; i <= 4; i++) pushByte(8'(i));
    @(negedge clk);
    check(inReady == 1'b0, "R11 full deasserts ready", inReady, 0);
    writeCfg(32'h507);
    check(inReady == 1'b1, "R10 clear frees fifo", inReady, 1);
    base = frCount;
    ctsIn = 1'b1;
    repeat (400) @(negedge clk);
    check(frCount == base && busy == 1'b0, "R10 cleared bytes not sent", frCount, base);
    ctsIn = 1'b0;
    pushByte(8'h5A);
    pushByte(8'h6B);
    pushByte(8'h7C);
    ctsIn = 1'b1;
    waitFrames(base + 3);
    checkFrame(base, 8'h5A, 8, 0, 0, 16, "R11 order first");
    checkFrame(base + 1, 8'h6B, 8, 0, 0, 16, "R11 order second");
    checkFrame(base + 2, 8'h7C, 8, 0, 0, 16, "R11 order third");
    waitIdle();
    writeCfg(32'h07);
  endtask

  task automatic t_null();
    int base = frCount;
    writeCfg(32'h207);
    waitFrames(base + 2);
    checkFrame(base, 8'h00, 8, 0, 0, 16, "R9 null char");
    checkFrame(base + 1, 8'h00, 8, 0, 0, 16, "R9 null repeats");
    writeCfg(32'h07);
    waitIdle();
    base = frCount;
    repeat (300) @(negedge clk);
    check(frCount == base && busy == 1'b0, "R9 stops when disabled", frCount, base);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_charLen();
    t_parity();
    t_stop();
    t_invert();
    t_flow();
    t_fifo();
    t_null();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule